// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a single-direction FIFO whose write side and read side each run on their own clock. The two clocks may be unrelated or may be the same clock. Each side qualifies its rising clock edge with an active-low select and an active-high enable. The read data bus floats whenever the read select is high. Storage is a register array written so that block RAM can be inferred. The pointers cross between the clock domains as Gray code through two-flop synchronizers, so every flag is conservative and reacts to the far side after a few cycles.

Two status outputs per side give the main state and an early warning. A timing-mode input is captured while the read side is held in reset and then stays fixed. In standard mode the read status means "not empty" and a read strobe fetches the next word. In fall-through mode the read status means "output ready": the oldest word is moved to the data bus without any strobe, and a read consumes it. The almost-empty and almost-full thresholds are taken from input buses while each side is in reset. Each threshold is compared in the domain of the side that reports it.

Top module: `dcfifo_pflag`

## Requirements
- R1: While and after reset with nothing written, rd_stat is 0, rd_aempty_n is 0, wr_stat is 1 and wr_afull_n is 1 (the last one when the almost-full offset is below DEPTH).
- R2: A word is stored only on a rising wr_clk edge with wr_csn = 0 and wr_en = 1. Any other combination leaves the FIFO contents unchanged.
- R3: A write attempted while wr_stat is 0 is ignored. Words already stored are not overwritten.
- R4: Words are read out in the order they were accepted, with their values unchanged.
- R5: In standard mode (mode_std = 1 at reset), rd_stat = 1 means at least one word is stored. A rising rd_clk edge with rd_csn = 0, rd_en = 1 and rd_stat = 1 reads a word, and that word appears on rd_data after that edge.
- R6: In fall-through mode (mode_std = 0 at reset), the oldest word reaches rd_data and rd_stat rises with no read strobe. A qualified read edge while rd_stat = 1 consumes that word.
- R7: wr_stat is 1 while space remains and 0 when the FIFO is full. Full means DEPTH words in standard mode and DEPTH+1 words in fall-through mode, where the output register adds one place. Both status outputs are active high for "usable".
- R8: rd_aempty_n is 0 when the stored level seen by the read domain is less than or equal to the almost-empty offset, and 1 otherwise. In fall-through mode the level counts the word held on the output.
- R9: wr_afull_n is 0 when the free memory locations seen by the write domain are less than or equal to the almost-full offset, and 1 otherwise.
- R10: rd_data is high impedance while rd_csn = 1.
- R11: mode_std, ae_ofs and af_ofs are captured during reset. Changing them after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_csn | input | 1 | Write select, active low |
| wr_en | input | 1 | Write enable, active high |
| wr_data | input | DATA_W | Write data |
| af_ofs | input | $clog2(DEPTH)+1 | Almost-full offset, captured in reset |
| wr_stat | output | 1 | Space available (not full / input ready) |
| wr_afull_n | output | 1 | Almost-full flag, active low |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_csn | input | 1 | Read select, active low, also output enable |
| rd_en | input | 1 | Read enable, active high |
| mode_std | input | 1 | 1 selects standard mode, 0 selects fall-through, captured in reset |
| ae_ofs | input | $clog2(DEPTH)+1 | Almost-empty offset, captured in reset |
| rd_data | output | DATA_W | Read data, tri-stated by rd_csn |
| rd_stat | output | 1 | Word available (not empty / output ready) |
| rd_aempty_n | output | 1 | Almost-empty flag, active low |

## Verification
Assertions check on every cycle that neither pointer pair drifts more than DEPTH apart across the synchronizers, so no overrun and no underrun occur. They also check that a full or empty state always carries its almost flag, and that a ready read status stays up until a read consumes it. Several behaviours can only be shown by the bench's scenarios: end-to-end data order, the exact threshold boundaries of both almost flags, the extra place in fall-through mode, the automatic fall-through of the first word, the tri-state bus, and that inputs captured at reset are ignored afterwards.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    TM_FWFT = 1'b0,
    TM_STD  = 1'b1
  } tmode_e;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn,
  input  logic          en,
  input  logic [PW-1:0] af_ofs,
  input  logic [PW-1:0] rgray_s,
  output logic          wfire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          wr_stat,
  output logic          afull_n
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, ofs_q, free_nx;
  logic          full_nx;

  assign wfire    = !csn && en && wr_stat;
  assign wbin_nx  = wbin + PW'(wfire);
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);
  assign rbin_s   = g2b(rgray_s);
  assign full_nx  = (wgray_nx == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
  assign free_nx  = PW'(DEPTH) - (wbin_nx - rbin_s);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      wr_stat <= 1'b1;
      afull_n <= 1'b1;
      ofs_q   <= af_ofs;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      wr_stat <= !full_nx;
      afull_n <= !(free_nx <= ofs_q);
    end
  end

  // R3: the write pointer never leads the synchronized read pointer by more than DEPTH
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (rst)
    (wbin - rbin_s) <= PW'(DEPTH));
  // R9: a full FIFO also reports almost full
  a_r9_full_is_afull: assert property (@(posedge clk) disable iff (rst)
    !wr_stat |-> !afull_n);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          csn,
  input  logic          en,
  input  logic          mode_std,
  input  logic [PW-1:0] ae_ofs,
  input  logic [PW-1:0] wgray_s,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          rd_stat,
  output logic          aempty_n
);
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  tmode_e        mode_q;
  logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, ofs_q, lvl_nx;
  logic          rfire, mem_ne, ov_nx, stat_nx, is_std;

  assign is_std   = (mode_q == TM_STD);
  assign rfire    = !csn && en && rd_stat;
  assign mem_ne   = (rgray != wgray_s);
  assign pop      = is_std ? rfire : (mem_ne && (!rd_stat || rfire));
  assign rbin_nx  = rbin + PW'(pop);
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);
  assign wbin_s   = g2b(wgray_s);
  assign ov_nx    = pop ? 1'b1 : (rfire ? 1'b0 : rd_stat);
  assign stat_nx  = is_std ? (rgray_nx != wgray_s) : ov_nx;
  assign lvl_nx   = (wbin_s - rbin_nx) + PW'(!is_std && ov_nx);
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= tmode_e'(mode_std);
      ofs_q    <= ae_ofs;
      rbin     <= '0;
      rgray    <= '0;
      rd_stat  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      rd_stat  <= stat_nx;
      aempty_n <= !(lvl_nx <= ofs_q);
    end
  end

  // R5: the read pointer never passes the synchronized write pointer
  a_r5_no_underrun: assert property (@(posedge clk) disable iff (rst)
    (wbin_s - rbin) <= PW'(DEPTH));
  // R5: in standard mode a non-empty status persists until a read
  a_r5_avail_holds: assert property (@(posedge clk) disable iff (rst)
    (is_std && rd_stat && !rfire) |=> rd_stat);
  // R6: in fall-through mode the ready status persists until a read consumes the word
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (!is_std && rd_stat && !rfire) |=> rd_stat);
  // R8: an empty read side also reports almost empty
  a_r8_empty_is_aempty: assert property (@(posedge clk) disable iff (rst)
    !rd_stat |-> !aempty_n);
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_csn,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     af_ofs,
  output logic              wr_stat,
  output logic              wr_afull_n,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_csn,
  input  logic              rd_en,
  input  logic              mode_std,
  input  logic [PW-1:0]     ae_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_stat,
  output logic              rd_aempty_n
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dout_q;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [AW-1:0]     waddr, raddr;
  logic              wfire, pop;

  initial assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
    else $error("DEPTH must be a power of two of at least 4");

  dcf_sync2 #(.W(PW)) i_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s)
  );
  dcf_sync2 #(.W(PW)) i_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s)
  );

  dcf_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) i_wr (
    .clk(wr_clk), .rst(wr_rst), .csn(wr_csn), .en(wr_en),
    .af_ofs(af_ofs), .rgray_s(rgray_s), .wfire(wfire), .waddr(waddr),
    .wgray(wgray), .wr_stat(wr_stat), .afull_n(wr_afull_n)
  );

  dcf_rd_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) i_rd (
    .clk(rd_clk), .rst(rd_rst), .csn(rd_csn), .en(rd_en),
    .mode_std(mode_std), .ae_ofs(ae_ofs), .wgray_s(wgray_s), .pop(pop),
    .raddr(raddr), .rgray(rgray), .rd_stat(rd_stat), .aempty_n(rd_aempty_n)
  );

  always_ff @(posedge wr_clk) begin
    if (wfire) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (pop) dout_q <= mem[raddr];
  end

  assign rd_data = rd_csn ? {DATA_W{1'bz}} : dout_q;

  // R4: the output register changes only when a word is fetched
  a_r4_dout_only_on_pop: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !pop |=> $stable(dout_q));
endmodule

// File: tb/test_dcfifo_pflag.sv
module test_dcfifo_pflag;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int PW = $clog2(DEPTH) + 1;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst, rd_rst, wr_csn, wr_en, rd_csn, rd_en, mode_std;
  logic [DW-1:0] wr_data;
  logic [PW-1:0] af_ofs, ae_ofs;
  wire  [DW-1:0] rd_data;
  logic          wr_stat, wr_afull_n, rd_stat, rd_aempty_n;

  int checks = 0, errors = 0;
  int q[$];
  bit cur_std;
  int cur_ae, cur_af;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcfifo_pflag #(.DATA_W(DW), .DEPTH(DEPTH)) i_dcfifo_pflag (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_csn(wr_csn), .wr_en(wr_en),
    .wr_data(wr_data), .af_ofs(af_ofs), .wr_stat(wr_stat), .wr_afull_n(wr_afull_n),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_csn(rd_csn), .rd_en(rd_en),
    .mode_std(mode_std), .ae_ofs(ae_ofs), .rd_data(rd_data), .rd_stat(rd_stat),
    .rd_aempty_n(rd_aempty_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cap_words();
    return cur_std ? DEPTH : DEPTH + 1;
  endfunction

  function automatic int mem_free(input int lvl);
    if (cur_std) return DEPTH - lvl;
    return DEPTH - ((lvl > 0) ? lvl - 1 : 0);
  endfunction

  task automatic settle();
    repeat (5) @(negedge wr_clk);
    repeat (5) @(negedge rd_clk);
  endtask

  task automatic do_reset(input bit std, input int ae, input int af);
    wr_rst = 1; rd_rst = 1;
    wr_csn = 1; wr_en = 0; rd_csn = 0; rd_en = 0; wr_data = '0;
    mode_std = std; ae_ofs = PW'(ae); af_ofs = PW'(af);
    cur_std = std; cur_ae = ae; cur_af = af;
    q.delete();
    repeat (4) @(negedge rd_clk);
    wr_rst = 0; rd_rst = 0;
  endtask

  task automatic wr_one(input int d, input bit cs_n, input bit en);
    @(negedge wr_clk);
    wr_csn = cs_n; wr_en = en; wr_data = DW'(d);
    if (!cs_n && en && wr_stat) q.push_back(d & 16'hFFFF);
    @(negedge wr_clk);
    wr_en = 0; wr_csn = 1;
  endtask

  task automatic rd_one(input bit cs_n, input bit en);
    bit fire;
    int exp;
    @(negedge rd_clk);
    rd_csn = cs_n; rd_en = en;
    fire = !cs_n && en && rd_stat && (q.size() > 0);
    exp = 0;
    if (fire) begin
      exp = q.pop_front();
      if (!cur_std) begin
        #1;
        chk(rd_data === DW'(exp), "R6 fall-through data on bus before read", int'(rd_data), exp);
      end
    end
    @(negedge rd_clk);
    rd_en = 0; rd_csn = 0;
    if (fire && cur_std) chk(rd_data === DW'(exp), "R4/R5 standard read data", int'(rd_data), exp);
  endtask

  task automatic check_flags(input string req);
    int lvl;
    settle();
    lvl = q.size();
    chk(rd_stat == (lvl > 0), {req, " rd_stat"}, rd_stat, lvl > 0);
    chk(wr_stat == (lvl < cap_words()), {req, " R7 wr_stat"}, wr_stat, lvl < cap_words());
    chk(rd_aempty_n == !(lvl <= cur_ae), {req, " R8 rd_aempty_n"}, rd_aempty_n, !(lvl <= cur_ae));
    chk(wr_afull_n == !(mem_free(lvl) <= cur_af), {req, " R9 wr_afull_n"}, wr_afull_n,
        !(mem_free(lvl) <= cur_af));
  endtask

  task automatic drain();
    for (int i = 0; i < 20 * DEPTH && q.size() > 0; i++) rd_one(1'b0, 1'b1);
    chk(q.size() == 0, "R4 drain complete", q.size(), 0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int r;
      r = int'($urandom % 4);
      if (r < 2) wr_one(int'($urandom), ($urandom % 10) == 0, ($urandom % 5) != 0);
      else rd_one(($urandom % 10) == 0, ($urandom % 4) != 0);
      if (i % 150 == 149) check_flags("R7/R8/R9 random");
    end
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // standard mode
    do_reset(1'b1, 3, 4);
    check_flags("R1 reset state std");
    chk(rd_stat == 0 && rd_aempty_n == 0, "R1 read flags", rd_stat, 0);

    rd_csn = 1; #1;
    chk(rd_data === {DW{1'bz}}, "R10 tri-state when deselected", int'(rd_data), 0);
    rd_csn = 0;

    wr_one(16'h1111, 1'b1, 1'b1);
    wr_one(16'h2222, 1'b0, 1'b0);
    settle();
    chk(rd_stat == 0, "R2 unqualified writes ignored", rd_stat, 0);
    check_flags("R2");

    wr_one(16'hA5A5, 1'b0, 1'b1);
    check_flags("R5 one word");
    rd_one(1'b0, 1'b1);
    check_flags("R5 after read");

    for (int i = 0; i < 3; i++) wr_one(16'h0100 + i, 1'b0, 1'b1);
    check_flags("R8 level at offset");
    wr_one(16'h0103, 1'b0, 1'b1);
    check_flags("R8 level above offset");
    drain();

    for (int i = 0; i < DEPTH - 5; i++) wr_one(16'h0200 + i, 1'b0, 1'b1);
    check_flags("R9 free above offset");
    wr_one(16'h02F0, 1'b0, 1'b1);
    check_flags("R9 free at offset");
    for (int i = 0; i < 7; i++) wr_one(16'h0300 + i, 1'b0, 1'b1);
    settle();
    chk(q.size() == DEPTH, "R3 model holds DEPTH", q.size(), DEPTH);
    chk(wr_stat == 0, "R7 full in standard mode", wr_stat, 0);
    wr_one(16'hDEAD, 1'b0, 1'b1);
    check_flags("R3 write while full");
    drain();

    ae_ofs = PW'(10); af_ofs = PW'(0); mode_std = 0;
    for (int i = 0; i < 5; i++) wr_one(16'h0400 + i, 1'b0, 1'b1);
    settle();
    chk(rd_aempty_n == 1, "R11 offset change after reset ignored", rd_aempty_n, 1);
    check_flags("R11 std");
    drain();

    random_run(1500);

    // fall-through mode
    do_reset(1'b0, 2, 3);
    check_flags("R1 reset state fwft");
    mode_std = 1;
    wr_one(16'hBEEF, 1'b0, 1'b1);
    settle();
    chk(rd_stat == 1, "R6 ready without read strobe", rd_stat, 1);
    chk(rd_data === 16'hBEEF, "R6 word on bus without strobe", int'(rd_data), 16'hBEEF);
    chk(rd_data === 16'hBEEF, "R11 mode change after reset ignored", int'(rd_data), 16'hBEEF);
    rd_one(1'b0, 1'b1);
    check_flags("R6 consumed");

    for (int i = 0; i < DEPTH + 3; i++) wr_one(16'h0500 + i, 1'b0, 1'b1);
    settle();
    chk(q.size() == DEPTH + 1, "R7 fall-through capacity", q.size(), DEPTH + 1);
    check_flags("R7 fwft full");
    drain();
    check_flags("R8 fwft empty");

    random_run(1500);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule